// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Fill, Freeze and Bypass Modes

This block is a read-only, direct-mapped instruction cache. It sits between a processor fetch port and a wide backing memory. A line holds eight 32-bit instructions, which is 256 bits. The path to memory has the same width, so a single transfer refills a whole line. A fetch that hits is answered in the cycle after it is accepted. A fetch that misses stalls the fetch port while one line request goes to memory, and the requested word is returned when the line arrives. The default size is 32 KB, which is 1024 lines.

A 3-bit mode input sets how the cache behaves. In fill mode (010), misses allocate the line. In hold mode (011), lookups still hit, but misses do not change the stored contents. In pass-through mode (100), every fetch goes to memory and nothing is stored. The encoding 000 and every other unused encoding behave like pass-through, so the cache never allocates in an unsupported mode. Changing the mode never discards stored lines.

Code can be overlaid safely through a two-register interface. Software first writes a start byte address. It then writes a word count to the control register. The block then clears the valid bit of every line that overlaps the range, at a rate of one line per cycle. While this runs, fetches stall and the control register reads back nonzero.

Top module: `fetch_cache`

## Requirements
- R1: After reset every line is invalid, `fetch_ready_o` is 1, `fetch_rvalid_o` is 0, and both configuration registers read 0.
- R2: In mode 010 or 011, a fetch to a valid line with a matching tag raises `fetch_rvalid_o` in the cycle after the accepting edge, with the addressed word and no memory request.
- R3: In mode 010 a miss issues exactly one memory request carrying the line address (the word address with its three low bits removed). The requested word is returned from the response, and the whole line is stored, so later fetches to any of its eight words hit.
- R4: In mode 011 a miss is served from memory but writes neither tag nor data, so a repeated fetch to that line misses again, while lines already stored keep hitting with their stored data.
- R5: In mode 100 every fetch issues a memory request and returns the current memory word, and the stored lines are left untouched.
- R6: Mode 000 and the unused encodings 001, 101, 110 and 111 behave exactly as mode 100.
- R7: A mode change never invalidates a line: a line stored before the change still hits when a looking-up mode is selected again.
- R8: Writing with `cfg_sel_i`=0 (offset 0x0) sets the start byte address, which reads back unchanged. Writing a count N with `cfg_sel_i`=1 (offset 0x4) invalidates every line that overlaps the bytes [start, start+4N). Other lines stay valid, and N=0 changes nothing.
- R9: A sweep clears one line per cycle over min(lines overlapped, number of lines) cycles, with indices wrapping past the last line. The control register reads nonzero exactly for those cycles, and `fetch_ready_o` is 0 throughout.
- R10: During a miss `fetch_ready_o` is 0 until the word returns, and `mem_req_o` is a single-cycle pulse, one per miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Cache mode, sampled when a fetch is accepted |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | ADDR_W-2 | Word address of the fetch |
| fetch_ready_o | output | 1 | Fetch port can accept a request |
| fetch_rvalid_o | output | 1 | Fetched word is valid |
| fetch_rdata_o | output | WORD_BITS | Fetched word |
| mem_req_o | output | 1 | Line request pulse to backing memory |
| mem_addr_o | output | ADDR_W-5 | Line address of the request |
| mem_rvalid_i | input | 1 | Line response valid |
| mem_rdata_i | input | LINE_BITS | Line data, word 0 in the low bits |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 1 | 0 selects the start address, 1 the control register |
| cfg_wdata_i | input | ADDR_W | Write data |
| cfg_rdata_o | output | ADDR_W | Read data of the selected register |

## Verification
The hardest behaviour to reach from the ports is a stale line. Freeze, bypass and a partial sweep only differ from plain refetching when memory has changed under a line that is still stored. The bench therefore bumps a version number that is mixed into every memory word between phases, so that a stale hit and a fresh miss return different values. A reference model predicts each hit or miss per mode. The sweeps use unaligned ranges, a range that wraps from the last index to index 0, a zero count and a range larger than the whole cache, which must clamp.

// File: rtl/fc_pkg.sv
package fc_pkg;

  localparam logic [2:0] FC_MODE_ENABLE = 3'b010;
  localparam logic [2:0] FC_MODE_FREEZE = 3'b011;

  typedef struct packed {
    logic lookup;
    logic fill;
  } fc_policy_t;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } fc_seq_e;

  // Every encoding other than fill and hold acts as pass-through.
  function automatic fc_policy_t fc_policy(input logic [2:0] m);
    fc_policy_t p;
    p.lookup = (m == FC_MODE_ENABLE) || (m == FC_MODE_FREEZE);
    p.fill   = (m == FC_MODE_ENABLE);
    return p;
  endfunction

endpackage

// File: rtl/fc_line_store.sv
module fc_line_store #(
  parameter int NUM_LINES = 1024,
  parameter int IDX_W     = 10,
  parameter int TAG_W     = 17,
  parameter int LINE_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  logic [TAG_W-1:0]     rd_tag_i,
  output logic                 rd_hit_o,
  output logic [LINE_BITS-1:0] rd_line_o,
  input  logic                 fill_we_i,
  input  logic [IDX_W-1:0]     fill_idx_i,
  input  logic [TAG_W-1:0]     fill_tag_i,
  input  logic [LINE_BITS-1:0] fill_line_i,
  input  logic                 clr_en_i,
  input  logic [IDX_W-1:0]     clr_idx_i
);

  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_BITS-1:0] data_q [NUM_LINES];

  // One valid flop per line; a fill sets it, a sweep step clears it.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (fill_we_i && (fill_idx_i == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
      end else if (clr_en_i && (clr_idx_i == IDX_W'(g))) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we_i) begin
      tag_q[fill_idx_i]  <= fill_tag_i;
      data_q[fill_idx_i] <= fill_line_i;
    end
  end

  assign rd_hit_o  = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_line_o = data_q[rd_idx_i];

  // R9: fill and sweep never compete for a valid bit
  assert_fill_sweep_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we_i && clr_en_i));

  // R8: a swept line is invalid afterwards
  assert_swept_line_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> !valid_q[$past(clr_idx_i)]);

  // R3: a filled line is valid afterwards
  assert_filled_line_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we_i |=> valid_q[$past(fill_idx_i)]);

endmodule

// File: rtl/fc_inval_sweep.sv
module fc_inval_sweep #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 5,
  parameter int IDX_W     = 10,
  parameter int NUM_LINES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  input  logic              step_ok_i,
  output logic              busy_o,
  output logic              clr_en_o,
  output logic [IDX_W-1:0]  clr_idx_o
);

  localparam int SW = ADDR_W + 3;

  // Number of lines touched by [start, start + 4*count), clamped to the cache size.
  function automatic logic [IDX_W:0] span_lines(input logic [ADDR_W-1:0] start,
                                                input logic [ADDR_W-1:0] count);
    logic [SW-1:0] lo, hi, diff;
    lo   = SW'(start);
    hi   = lo + (SW'(count) << 2) - SW'(1);
    diff = (hi >> OFF_W) - (lo >> OFF_W) + SW'(1);
    if (count == '0) return '0;
    if (diff > SW'(NUM_LINES)) return (IDX_W+1)'(NUM_LINES);
    return diff[IDX_W:0];
  endfunction

  logic [ADDR_W-1:0] start_q;
  logic [IDX_W:0]    left_q;
  logic [IDX_W-1:0]  cur_q;
  logic              ctrl_wr;
  logic              sweep_step;

  assign busy_o     = (left_q != '0);
  assign ctrl_wr    = cfg_we_i && cfg_sel_i && !busy_o;
  assign sweep_step = busy_o && step_ok_i;
  assign clr_en_o   = sweep_step;
  assign clr_idx_o  = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      left_q  <= '0;
      cur_q   <= '0;
    end else begin
      if (cfg_we_i && !cfg_sel_i) begin
        start_q <= cfg_wdata_i;
      end
      if (ctrl_wr) begin
        left_q <= span_lines(start_q, cfg_wdata_i);
        cur_q  <= start_q[OFF_W+IDX_W-1:OFF_W];
      end else if (sweep_step) begin
        left_q <= left_q - (IDX_W+1)'(1);
        cur_q  <= cur_q + IDX_W'(1);
      end
    end
  end

  assign cfg_rdata_o = cfg_sel_i ? ADDR_W'(left_q) : start_q;

  // R9: each granted step retires exactly one line
  assert_one_line_per_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_step |=> left_q == $past(left_q) - (IDX_W+1)'(1));

  // R8: a nonzero count written while idle starts a sweep
  assert_count_starts_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_sel_i && !busy_o && cfg_wdata_i != '0) |=> busy_o);

  // R8: a zero count leaves the sweep idle
  assert_zero_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_sel_i && !busy_o && cfg_wdata_i == '0) |=> !busy_o);

endmodule

// File: rtl/fc_fetch_seq.sv
module fc_fetch_seq
  import fc_pkg::*;
#(
  parameter int WADDR_W   = 30,
  parameter int WOFF_W    = 3,
  parameter int IDX_W     = 10,
  parameter int TAG_W     = 17,
  parameter int LINE_BITS = 256,
  parameter int WORD_BITS = 32,
  localparam int LADDR_W  = WADDR_W - WOFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode_i,
  input  logic                 fetch_req_i,
  input  logic [WADDR_W-1:0]   fetch_addr_i,
  output logic                 fetch_ready_o,
  output logic                 fetch_rvalid_o,
  output logic [WORD_BITS-1:0] fetch_rdata_o,
  input  logic                 sweep_busy_i,
  output logic                 idle_o,
  output logic [IDX_W-1:0]     lk_idx_o,
  output logic [TAG_W-1:0]     lk_tag_o,
  input  logic                 lk_hit_i,
  input  logic [LINE_BITS-1:0] lk_line_i,
  output logic                 mem_req_o,
  output logic [LADDR_W-1:0]   mem_addr_o,
  input  logic                 mem_rvalid_i,
  input  logic [LINE_BITS-1:0] mem_rdata_i,
  output logic                 fill_we_o,
  output logic [IDX_W-1:0]     fill_idx_o,
  output logic [TAG_W-1:0]     fill_tag_o,
  output logic [LINE_BITS-1:0] fill_line_o
);

  function automatic logic [WORD_BITS-1:0] pick_word(input logic [LINE_BITS-1:0] line,
                                                     input logic [WOFF_W-1:0] off);
    return line[off*WORD_BITS +: WORD_BITS];
  endfunction

  fc_seq_e              state_q;
  logic [WADDR_W-1:0]   addr_q;
  logic                 fill_q;
  logic                 req_q;
  logic                 rvalid_q;
  logic [WORD_BITS-1:0] rdata_q;

  fc_policy_t policy;
  logic       accept;
  logic       hit_use;
  logic       resp_arrive;

  assign policy        = fc_policy(mode_i);
  assign idle_o        = (state_q == SEQ_IDLE);
  assign fetch_ready_o = idle_o && !sweep_busy_i;
  assign accept        = fetch_req_i && fetch_ready_o;
  assign lk_idx_o      = fetch_addr_i[WOFF_W+IDX_W-1:WOFF_W];
  assign lk_tag_o      = fetch_addr_i[WADDR_W-1:WOFF_W+IDX_W];
  assign hit_use       = accept && policy.lookup && lk_hit_i;
  assign resp_arrive   = (state_q == SEQ_WAIT) && mem_rvalid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      addr_q   <= '0;
      fill_q   <= 1'b0;
      req_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      req_q    <= 1'b0;
      rvalid_q <= 1'b0;
      if (state_q == SEQ_IDLE) begin
        if (hit_use) begin
          rvalid_q <= 1'b1;
          rdata_q  <= pick_word(lk_line_i, fetch_addr_i[WOFF_W-1:0]);
        end else if (accept) begin
          state_q <= SEQ_WAIT;
          addr_q  <= fetch_addr_i;
          fill_q  <= policy.fill;
          req_q   <= 1'b1;
        end
      end else if (resp_arrive) begin
        state_q  <= SEQ_IDLE;
        rvalid_q <= 1'b1;
        rdata_q  <= pick_word(mem_rdata_i, addr_q[WOFF_W-1:0]);
      end
    end
  end

  assign fetch_rvalid_o = rvalid_q;
  assign fetch_rdata_o  = rdata_q;
  assign mem_req_o      = req_q;
  assign mem_addr_o     = addr_q[WADDR_W-1:WOFF_W];
  assign fill_we_o      = resp_arrive && fill_q;
  assign fill_idx_o     = addr_q[WOFF_W+IDX_W-1:WOFF_W];
  assign fill_tag_o     = addr_q[WADDR_W-1:WOFF_W+IDX_W];
  assign fill_line_o    = mem_rdata_i;

  // R2: a usable hit answers in the next cycle
  assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_use |=> fetch_rvalid_o);

  // R10: line requests are single-cycle pulses
  assert_req_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  // R5: a non-looking-up mode always goes to memory
  assert_passthrough_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !policy.lookup) |=> mem_req_o);

  // R3: a returned word comes from a hit or from a memory response
  assert_rvalid_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rvalid_o |-> ($past(hit_use) || $past(resp_arrive)));

endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
  import fc_pkg::*;
#(
  parameter int CACHE_BYTES = 32768,
  parameter int LINE_BITS   = 256,
  parameter int WORD_BITS   = 32,
  parameter int ADDR_W      = 32,
  localparam int LINE_BYTES = LINE_BITS / 8,
  localparam int NUM_LINES  = CACHE_BYTES / LINE_BYTES,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int WB_W       = $clog2(WORD_BITS / 8),
  localparam int WADDR_W    = ADDR_W - WB_W,
  localparam int WOFF_W     = OFF_W - WB_W,
  localparam int TAG_W      = WADDR_W - WOFF_W - IDX_W,
  localparam int LADDR_W    = WADDR_W - WOFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode_i,
  input  logic                 fetch_req_i,
  input  logic [WADDR_W-1:0]   fetch_addr_i,
  output logic                 fetch_ready_o,
  output logic                 fetch_rvalid_o,
  output logic [WORD_BITS-1:0] fetch_rdata_o,
  output logic                 mem_req_o,
  output logic [LADDR_W-1:0]   mem_addr_o,
  input  logic                 mem_rvalid_i,
  input  logic [LINE_BITS-1:0] mem_rdata_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_sel_i,
  input  logic [ADDR_W-1:0]    cfg_wdata_i,
  output logic [ADDR_W-1:0]    cfg_rdata_o
);

  logic                 sweep_busy;
  logic                 seq_idle;
  logic                 clr_en;
  logic [IDX_W-1:0]     clr_idx;
  logic [IDX_W-1:0]     lk_idx;
  logic [TAG_W-1:0]     lk_tag;
  logic                 lk_hit;
  logic [LINE_BITS-1:0] lk_line;
  logic                 fill_we;
  logic [IDX_W-1:0]     fill_idx;
  logic [TAG_W-1:0]     fill_tag;
  logic [LINE_BITS-1:0] fill_line;

  fc_fetch_seq #(
    .WADDR_W  (WADDR_W),
    .WOFF_W   (WOFF_W),
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W),
    .LINE_BITS(LINE_BITS),
    .WORD_BITS(WORD_BITS)
  ) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .fetch_ready_o (fetch_ready_o),
    .fetch_rvalid_o(fetch_rvalid_o),
    .fetch_rdata_o (fetch_rdata_o),
    .sweep_busy_i  (sweep_busy),
    .idle_o        (seq_idle),
    .lk_idx_o      (lk_idx),
    .lk_tag_o      (lk_tag),
    .lk_hit_i      (lk_hit),
    .lk_line_i     (lk_line),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rvalid_i  (mem_rvalid_i),
    .mem_rdata_i   (mem_rdata_i),
    .fill_we_o     (fill_we),
    .fill_idx_o    (fill_idx),
    .fill_tag_o    (fill_tag),
    .fill_line_o   (fill_line)
  );

  fc_line_store #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W),
    .LINE_BITS(LINE_BITS)
  ) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx_i   (lk_idx),
    .rd_tag_i   (lk_tag),
    .rd_hit_o   (lk_hit),
    .rd_line_o  (lk_line),
    .fill_we_i  (fill_we),
    .fill_idx_i (fill_idx),
    .fill_tag_i (fill_tag),
    .fill_line_i(fill_line),
    .clr_en_i   (clr_en),
    .clr_idx_i  (clr_idx)
  );

  fc_inval_sweep #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .IDX_W    (IDX_W),
    .NUM_LINES(NUM_LINES)
  ) sweep_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .step_ok_i  (seq_idle),
    .busy_o     (sweep_busy),
    .clr_en_o   (clr_en),
    .clr_idx_o  (clr_idx)
  );

  // R9: no fetch is accepted while a sweep runs
  assert_stall_during_sweep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> !fetch_ready_o);

  // R10: the port stays stalled from a miss until its word returns
  assert_stall_during_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !fetch_ready_o);

endmodule

// File: tb/fetch_cache_tb_top.sv
module fetch_cache_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CB  = 256;
  localparam int NL  = 8;
  localparam int WPL = 8;
  localparam int LAT = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode_i = 3'b000;
  logic         fetch_req_i = 1'b0;
  logic [29:0]  fetch_addr_i = '0;
  logic         fetch_ready_o, fetch_rvalid_o;
  logic [31:0]  fetch_rdata_o;
  logic         mem_req_o;
  logic [26:0]  mem_addr_o;
  logic         mem_rvalid_i = 1'b0;
  logic [255:0] mem_rdata_i = '0;
  logic         cfg_we_i = 1'b0, cfg_sel_i = 1'b0;
  logic [31:0]  cfg_wdata_i = '0;
  logic [31:0]  cfg_rdata_o;

  int n_chk = 0, n_fail = 0, mem_reqs = 0, cycles = 0, ver = 0, lat_cnt = 0;
  logic [26:0] pend_addr = '0;
  logic prev_req = 1'b0;

  bit mv [NL];
  int mt [NL];
  int mver [NL];

  fetch_cache #(.CACHE_BYTES(CB)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memf(input int w, input int v);
    return (32'(w) * 32'h9E3779B1) ^ (32'(v) << 24) ^ 32'h0F0F_1234;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // Fixed-latency backing memory
  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_rvalid_i <= 1'b0;
    prev_req <= mem_req_o;
    if (mem_req_o) begin
      mem_reqs <= mem_reqs + 1;
      pend_addr <= mem_addr_o;
      lat_cnt <= LAT;
      if (prev_req) begin
        n_fail++; n_chk++;
        $display("FAIL R10 request longer than one cycle act=1 exp=0");
      end
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mem_rvalid_i <= 1'b1;
        for (int k = 0; k < WPL; k++)
          mem_rdata_i[k*32 +: 32] <= memf(int'(pend_addr) * WPL + k, ver);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_fetch(input int w, input string lbl);
    int idx, tag, cyc, req0, m;
    bit exp_hit;
    string rq;
    logic [31:0] exp;
    while (!fetch_ready_o) @(negedge clk);
    m = int'(mode_i);
    idx = (w / WPL) % NL;
    tag = w / (WPL * NL);
    exp_hit = (m == 2 || m == 3) && mv[idx] && mt[idx] == tag;
    if (lbl != "") rq = lbl;
    else if (m == 2) rq = exp_hit ? "R2" : "R3";
    else if (m == 3) rq = "R4";
    else if (m == 4) rq = "R5";
    else rq = "R6";
    req0 = mem_reqs;
    fetch_req_i = 1'b1;
    fetch_addr_i = 30'(w);
    @(negedge clk);
    fetch_req_i = 1'b0;
    cyc = 1;
    if (!exp_hit) chk(fetch_ready_o == 1'b0, "R10", "ready during miss", 32'(fetch_ready_o), 0);
    while (!fetch_rvalid_o && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    exp = exp_hit ? memf(w, mver[idx]) : memf(w, ver);
    chk(fetch_rvalid_o && fetch_rdata_o == exp, rq, "fetch data", fetch_rdata_o, exp);
    if (exp_hit) begin
      chk(cyc == 1, rq, "hit latency", 32'(cyc), 1);
      chk(mem_reqs == req0, rq, "hit requests", 32'(mem_reqs - req0), 0);
    end else begin
      chk(mem_reqs == req0 + 1, "R10", "miss requests", 32'(mem_reqs - req0), 1);
      if (m == 2) begin
        mv[idx] = 1'b1;
        mt[idx] = tag;
        mver[idx] = ver;
      end
    end
  endtask

  task automatic run(input int first, input int n, input string lbl);
    for (int i = 0; i < n; i++) do_fetch(first + i, lbl);
  endtask

  task automatic inval(input int start, input int cnt);
    longint lo, hi, nl;
    int busy;
    lo = longint'(start);
    hi = lo + 4 * longint'(cnt) - 1;
    nl = (cnt == 0) ? 0 : (hi >>> 5) - (lo >>> 5) + 1;
    if (nl > NL) nl = NL;
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 32'(start);
    @(negedge clk);
    cfg_sel_i = 1'b1; cfg_wdata_i = 32'(cnt);
    @(negedge clk);
    cfg_we_i = 1'b0;
    busy = 0;
    while (cfg_rdata_o != 0 && busy < 100) begin
      chk(fetch_ready_o == 1'b0, "R9", "ready during sweep", 32'(fetch_ready_o), 0);
      @(negedge clk);
      busy++;
    end
    chk(busy == nl, "R9", "sweep cycles", 32'(busy), 32'(nl));
    cfg_sel_i = 1'b0;
    #1;
    chk(cfg_rdata_o == 32'(start), "R8", "start readback", cfg_rdata_o, 32'(start));
    for (longint k = 0; k < nl; k++) mv[int'(((lo >>> 5) + k) % NL)] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      mv[i] = 1'b0; mt[i] = 0; mver[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(fetch_ready_o == 1'b1, "R1", "ready", 32'(fetch_ready_o), 1);
    chk(fetch_rvalid_o == 1'b0, "R1", "rvalid", 32'(fetch_rvalid_o), 0);
    cfg_sel_i = 1'b1; #1;
    chk(cfg_rdata_o == 0, "R1", "control", cfg_rdata_o, 0);
    cfg_sel_i = 1'b0; #1;
    chk(cfg_rdata_o == 0, "R1", "start", cfg_rdata_o, 0);

    // R2/R3: fill all lines, then hit every word
    mode_i = 3'b010;
    run(0, NL * WPL, "");
    run(0, NL * WPL, "");

    // R4: overlay, then hold mode: stale hits, aliasing misses without fill
    ver = 1;
    mode_i = 3'b011;
    run(0, NL * WPL, "");
    run(NL * WPL, NL * WPL, "");
    run(NL * WPL, WPL, "");

    // R5: pass-through
    mode_i = 3'b100;
    run(0, 2 * WPL, "");

    // R6: legacy and unused encodings
    foreach (mode_i[b]) ;
    mode_i = 3'b000; run(0, WPL, "");
    mode_i = 3'b001; run(WPL, WPL, "");
    mode_i = 3'b101; run(0, 4, "");
    mode_i = 3'b110; run(3 * WPL, 4, "");
    mode_i = 3'b111; run(NL * WPL, 4, "");

    // R7: lines survive mode changes and hit stale
    mode_i = 3'b010;
    run(WPL, WPL, "R7");

    // R8/R9: aligned sweep of lines 1..2, then refetch everything
    inval(32'h20, 16);
    run(0, NL * WPL, "");
    // R8: unaligned sweep touching lines 2 and 3
    ver = 2;
    inval(32'h5C, 2);
    run(0, NL * WPL, "");
    // R8: zero count changes nothing
    inval(32'h40, 0);
    run(2 * WPL, WPL, "R8");
    // R9: index wrap from line 7 to line 0
    ver = 3;
    inval(32'hE0, 16);
    run(0, NL * WPL, "");
    // R9: range larger than the cache clamps to every line
    ver = 4;
    inval(32'h100, 1000);
    run(NL * WPL, NL * WPL, "");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule